// File: doc/BRIEF.md
# Dual-Edge Pixel Lane Deserializer

This block sits behind the comparators of a reduced-swing pixel link. It receives nine single-ended data lanes and the forward clock that came with them. Each lane carries two bits of one colour component in every clock period. The first half of the period carries the lower bit of the pair, and the second half carries the upper bit. The block captures the two halves on opposite clock edges. It then interleaves the captured bits back into their true positions and registers one 18-bit RGB word on the rising edge that completes each pair. A strobe marks each word that was built from a full pair.

A board-level strap can invert every received lane bit. This recovers the correct data when the differential pairs of the link are routed crossed. The strap is wired to a rail and only changes while the block is held in reset. The output word and strobe belong to the rising-edge domain of the clock input.

Top module: `pxb_deser`

## Requirements
- R1: While `rst_n_i` is low at a rising clock edge, that edge clears `px_o` to zero and drives `px_valid_o` low.
- R2: The lane value present at a falling clock edge is the even half. Lane index `3*c + l` (colour c, lane l, with l from 0 to 2) supplies bit `2*l` of colour field c.
- R3: The lane value present at the following rising clock edge is the odd half. Lane `3*c + l` supplies bit `2*l + 1` of colour field c, and the word appears on `px_o` at that same rising edge.
- R4: Colour field c occupies `px_o[6*c+5 : 6*c]`. Red is c=0 (`px_o[5:0]`), green is c=1 (`px_o[11:6]`) and blue is c=2 (`px_o[17:12]`).
- R5: With `inv_strap_i` high, every output bit is the complement of the received lane bit. The strap is held constant whenever reset is released.
- R6: With `inv_strap_i` low, lane bits reach `px_o` unchanged.
- R7: Once valid, `px_valid_o` stays high on every rising edge without reset, and a new word is produced every clock period.
- R8: After reset is released, `px_valid_o` stays low until a falling edge has captured an even half with reset inactive.
- R9: Lane changes between the sampling edges have no effect on the assembled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Forward link clock; falling edge takes the even half, rising edge takes the odd half |
| rst_n_i | input | 1 | Synchronous active-low reset |
| lane_i | input | 9 | Received lane bits, index 3*colour + lane |
| inv_strap_i | input | 1 | Static polarity strap; high inverts all lane data |
| px_o | output | 18 | Assembled pixel word: red [5:0], green [11:6], blue [17:12] |
| px_valid_o | output | 1 | High while px_o holds a word built from a full even/odd pair |

## Verification
The checker assumes that the lanes are stable around each clock edge. It also assumes that the polarity strap never moves while reset is released. Under those conditions, the odd bits seen at a rising edge can be compared one period later against the registered word. The stimulus drives the lanes one time unit after each edge, so every value is settled well before it is sampled. The strap changes only in the middle of a reset. Deliberate glitches are placed strictly between edges, which exercises R9 without breaking the stability assumption.

// File: rtl/pxb_pkg.sv
// Package: shared geometry of the pixel lane deserializer.
// Assumes two bits per lane per clock period (one per clock edge).
package pxb_pkg;
    parameter int COLORS        = 3;
    parameter int LANES_PER_CLR = 3;
    parameter int BITS_PER_LANE = 2;
    localparam int CLR_BITS   = LANES_PER_CLR * BITS_PER_LANE;
    localparam int LANES      = COLORS * LANES_PER_CLR;
    localparam int WORD_BITS  = COLORS * CLR_BITS;
endpackage

// File: rtl/pxb_polarity.sv
// Module: applies the static polarity strap to every received lane bit.
// Assumes the strap is constant outside reset; purely combinational.
module pxb_polarity #(
    parameter int W = 9
) (
    input  logic [W-1:0] raw_i,
    input  logic         inv_i,
    output logic [W-1:0] pol_o
);
    // Per-lane conditional inversion.
    for (genvar g = 0; g < W; g++) begin : g_inv
        assign pol_o[g] = raw_i[g] ^ inv_i;
    end
endmodule

// File: rtl/pxb_half_capture.sv
// Module: holds the even half of each lane pair, taken on the falling edge.
// Assumes lanes are settled at the falling edge; reset is sampled on that edge.
module pxb_half_capture #(
    parameter int W = 9
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         seen_o
);
    // Falling-edge capture of the first half and a flag that one has been taken.
    always_ff @(negedge clk_i) begin
        if (!rst_n_i) begin
            q_o    <= '0;
            seen_o <= 1'b0;
        end else begin
            q_o    <= d_i;
            seen_o <= 1'b1;
        end
    end
endmodule

// File: rtl/pxb_interleave.sv
// Module: places the even and odd lane halves at their bit positions in the word.
// Assumes lane index = colour*LANES_PER_CLR + lane; purely combinational.
module pxb_interleave
    import pxb_pkg::*;
(
    input  logic [LANES-1:0]     even_i,
    input  logic [LANES-1:0]     odd_i,
    output logic [WORD_BITS-1:0] word_o
);
    // Each lane contributes bit 2l (even) and bit 2l+1 (odd) of its colour.
    for (genvar c = 0; c < COLORS; c++) begin : g_clr
        for (genvar l = 0; l < LANES_PER_CLR; l++) begin : g_lane
            localparam int LIDX = c * LANES_PER_CLR + l;
            localparam int BIDX = c * CLR_BITS + BITS_PER_LANE * l;
            assign word_o[BIDX]     = even_i[LIDX];
            assign word_o[BIDX + 1] = odd_i[LIDX];
        end
    end
endmodule

// File: rtl/pxb_deser.sv
// Module: top of the dual-edge pixel lane deserializer.
// Even halves are taken on the falling edge and odd halves on the rising edge.
// The completed word is registered on that rising edge.
// Assumes the strap is static while out of reset.
module pxb_deser
    import pxb_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_n_i,
    input  logic [LANES-1:0]     lane_i,
    input  logic                 inv_strap_i,
    output logic [WORD_BITS-1:0] px_o,
    output logic                 px_valid_o
);
    logic [LANES-1:0]     lane_pol;
    logic [LANES-1:0]     even_q;
    logic                 even_seen;
    logic [WORD_BITS-1:0] word_c;

    pxb_polarity #(.W(LANES)) u_pol (
        .raw_i (lane_i),
        .inv_i (inv_strap_i),
        .pol_o (lane_pol)
    );

    pxb_half_capture #(.W(LANES)) u_even (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (lane_pol),
        .q_o     (even_q),
        .seen_o  (even_seen)
    );

    pxb_interleave u_mix (
        .even_i (even_q),
        .odd_i  (lane_pol),
        .word_o (word_c)
    );

    // Rising-edge register: completes the pair and publishes the word.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            px_o       <= '0;
            px_valid_o <= 1'b0;
        end else begin
            if (even_seen) px_o <= word_c;
            px_valid_o <= even_seen;
        end
    end
endmodule

// File: rtl/pxb_deser_chk.sv
// Module: property checker for pxb_deser, attached by bind.
// Assumes lanes are stable around each rising edge.
module pxb_deser_chk
    import pxb_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_n_i,
    input logic [LANES-1:0]     lane_i,
    input logic                 inv_strap_i,
    input logic [WORD_BITS-1:0] px_o,
    input logic                 px_valid_o
);
    logic [LANES-1:0] odd_seen;

    // Gathers the odd bit of every lane pair from the output word.
    always_comb begin
        for (int c = 0; c < COLORS; c++)
            for (int l = 0; l < LANES_PER_CLR; l++)
                odd_seen[c*LANES_PER_CLR + l] = px_o[c*CLR_BITS + BITS_PER_LANE*l + 1];
    end

    assert_reset_clears_R1: assert property (@(posedge clk_i)
        !rst_n_i |=> (!px_valid_o && px_o == '0));

    assert_odd_half_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        px_valid_o |-> odd_seen == $past(lane_i ^ {LANES{inv_strap_i}}));

    assert_strap_static_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $stable(inv_strap_i));

    assert_valid_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        px_valid_o |=> px_valid_o);
endmodule

bind pxb_deser pxb_deser_chk u_chk (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .lane_i      (lane_i),
    .inv_strap_i (inv_strap_i),
    .px_o        (px_o),
    .px_valid_o  (px_valid_o)
);

// File: tb/pxb_deser_tb.sv
module pxb_deser_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam logic [17:0] VEC [NVEC] = '{
        18'h00000, 18'h3FFFF, 18'h15555, 18'h2AAAA,
        18'h0003F, 18'h00FC0, 18'h3F000, 18'h12345
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  lane = '0;
    logic        inv = 1'b0;
    logic [17:0] px;
    logic        vld;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pxb_deser u_dut (
        .clk_i(clk), .rst_n_i(rst_n), .lane_i(lane),
        .inv_strap_i(inv), .px_o(px), .px_valid_o(vld)
    );

    function automatic logic [8:0] lanes_of(logic [17:0] p, int half);
        logic [8:0] r;
        for (int c = 0; c < 3; c++)
            for (int l = 0; l < 3; l++)
                r[c*3 + l] = p[c*6 + 2*l + half];
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [17:0] act, logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called just after a rising edge; drives one pixel and checks it.
    task automatic send(logic [17:0] p, bit glitch);
        lane = lanes_of(p, 0);
        if (glitch) begin
            #1 lane = ~lane;  // R9 glitch inside high phase
            #1 lane = lanes_of(p, 0);
        end
        @(negedge clk); #1 lane = lanes_of(p, 1);
        if (glitch) begin
            #1 lane = ~lane;  // R9 glitch inside low phase
            #1 lane = lanes_of(p, 1);
        end
        @(posedge clk); #2;
        check(px == (p ^ {18{inv}}), glitch ? "R9" : "R2,R3,R4,R5,R6", px, p ^ {18{inv}});
        check(vld == 1'b1, "R7", {17'b0, vld}, 18'd1);
    endtask

    task automatic reset_release(bit strap);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check(vld == 1'b0 && px == '0, "R1", px, 18'd0);
        inv = strap;
        repeat (2) @(posedge clk);
        @(negedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #2;
        check(vld == 1'b0, "R8", {17'b0, vld}, 18'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Pass with strap low (R6), then strap high (R5).
        for (int s = 0; s < 2; s++) begin
            reset_release(s[0]);
            for (int i = 0; i < NVEC; i++) send(VEC[i], 1'b0);
        end
        // R9: glitches between edges are ignored.
        reset_release(1'b0);
        send(18'h2D2D2, 1'b1);
        send(18'h05A5A, 1'b1);
        // R7: continuous stream, one word per period.
        for (int i = 0; i < 4; i++) send(18'h01111 << i, 1'b0);
        // R1: reset mid-stream clears output.
        rst_n = 1'b0;
        @(posedge clk); #2;
        check(vld == 1'b0 && px == '0, "R1", px, 18'd0);
        // R8: valid returns only after a fresh even half.
        @(negedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #2;
        check(vld == 1'b0, "R8", {17'b0, vld}, 18'd0);
        send(18'h3C3C3, 1'b0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule